// File: doc/BRIEF.md
# Fused Immediate Arithmetic Unit

This unit is a purely combinational execute stage for a 64-bit integer core that uses compact 3-bit register fields. A 32-bit instruction word goes in. The unit expands its compact register fields into full 5-bit register-file indices and sends them out on read-address and write-address ports. It then takes the read data that comes back and produces one 64-bit destination value.

The unit recognises four operations, each in a full-width form and a word form:

- multiply by immediate, then add a register;
- add an immediate and a register;
- subtract a register from an immediate;
- add three registers.

A write-request flag shows that the word was one of these eight encodings. A word that is not one of them yields a zero result and no write request.

Fetch, the register file, hazard handling and exceptions live outside the unit. The enclosing core drives the instruction and returns the read data within the same cycle.

Top module: `fia_unit`

## Requirements
- R1: Source fields are expanded to register indices: code 000 maps to index 0 (the zero register), and codes 001..111 map to indices 9..15. The first source is taken from instruction bits [17:15], the second from [22:20] and the third from [29:27]. The three read addresses are driven from these fields for every instruction word, recognised or not.
- R2: The destination field in bits [9:7] maps code n to index 8+n on the write-address port, for every instruction word.
- R3: Opcode 0001111 with bits [14:13]=10 and [12:10]=000 forms the two-source group. In this group, subfunction [19:18]=00 gives src1 * imm9 + src2, with the 9-bit immediate taken from bits [31:23]. When the second source code is 000, the result equals src1 * imm9.
- R4: In the two-source group, subfunction 10 gives src1 + imm9 + src2.
- R5: Opcode 0011011 with bits [14:13]=11 and [12:10]=000 and subfunction 00 gives imm12 - src1, with the 12-bit immediate taken from bits [31:20].
- R6: Opcode 0001111 with bits [14:13]=11, [12:10]=000, [31:30]=00, [26:23]=0000 and subfunction 00 gives src1 + src2 + src3.
- R7: The word forms compute on the low 32 bits and copy bit 31 into bits [63:32] of the result. The word form of R3 is subfunction 01, of R4 is subfunction 11, and of R5 and R6 is subfunction 01.
- R8: The write-request flag is 1 only for the eight encodings of R3..R7. For any other word the flag is 0 and the result is zero.
- R9: Both immediates are sign-extended to 64 bits before use, so an immediate with its top bit set acts as a negative value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode and execute |
| rs1_addr_o | output | 5 | Register-file read index of the first source |
| rs2_addr_o | output | 5 | Register-file read index of the second source |
| rs3_addr_o | output | 5 | Register-file read index of the third source |
| rd_addr_o | output | 5 | Register-file write index of the destination |
| rs1_data_i | input | 64 | Read data for the first source |
| rs2_data_i | input | 64 | Read data for the second source |
| rs3_data_i | input | 64 | Read data for the third source |
| result_o | output | 64 | Destination value; zero when the word is not recognised |
| wr_en_o | output | 1 | Write request, high only for a recognised encoding |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path, a 32-bit word width and 3-bit register fields. These settings bring several behaviours within reach:

- carries and overflows across bit 31, which the word forms must discard before sign-extending;
- 64-bit wraparound of products and sums;
- the complete mapping of all eight codes for each of the three sources and the destination.

Random words near the recognised encodings test each match condition. Directed cases cover the zero second source, all-ones and most-negative immediates, and the boundaries of the word result.

// File: rtl/fia_pkg.sv
package fia_pkg;

    localparam logic [6:0] OPC_MISC_MEM  = 7'b0001111;
    localparam logic [6:0] OPC_OP_IMM_32 = 7'b0011011;

    localparam logic [1:0] GRP_TWO_SRC   = 2'b10;
    localparam logic [1:0] GRP_THREE_SRC = 2'b11;
    localparam logic [1:0] GRP_REV_SUB   = 2'b11;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MULADD,
        OP_MULADDW,
        OP_ADDADD,
        OP_ADDADDW,
        OP_RSUB,
        OP_RSUBW,
        OP_ADD3,
        OP_ADD3W
    } fia_op_e;

    typedef struct packed {
        logic [6:0] opcode;
        logic [2:0] rd_code;
        logic [2:0] sel3;
        logic [1:0] grp;
        logic [2:0] rs1_code;
        logic [1:0] sub;
        logic [2:0] rs2_code;
        logic [3:0] nibble;
        logic [2:0] rs3_code;
        logic [1:0] top2;
    } fia_fields_t;

    function automatic logic op_is_word(input fia_op_e op);
        return (op == OP_MULADDW) || (op == OP_ADDADDW) ||
               (op == OP_RSUBW)   || (op == OP_ADD3W);
    endfunction

    function automatic fia_fields_t split_word(input logic [31:0] w);
        fia_fields_t f;
        f.opcode   = w[6:0];
        f.rd_code  = w[9:7];
        f.sel3     = w[12:10];
        f.grp      = w[14:13];
        f.rs1_code = w[17:15];
        f.sub      = w[19:18];
        f.rs2_code = w[22:20];
        f.nibble   = w[26:23];
        f.rs3_code = w[29:27];
        f.top2     = w[31:30];
        return f;
    endfunction

endpackage

// File: rtl/fia_regmap.sv
module fia_regmap #(
    parameter int NSRC   = 3,
    parameter int SPEC_W = 3,
    parameter int REG_AW = 5
) (
    input  logic [SPEC_W-1:0] src_code_i [NSRC],
    input  logic [SPEC_W-1:0] dst_code_i,
    output logic [REG_AW-1:0] src_addr_o [NSRC],
    output logic [REG_AW-1:0] dst_addr_o
);

    localparam int BANK_BASE = 1 << SPEC_W;
    localparam logic [REG_AW-1:0] BASE_IDX = REG_AW'(BANK_BASE);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_comb begin
            if (src_code_i[g] == '0) begin
                src_addr_o[g] = '0;
            end else begin
                src_addr_o[g] = BASE_IDX + REG_AW'(src_code_i[g]);
            end
        end

        always_comb begin
            p_src_zero_map_r1: assert ((src_addr_o[g] == '0) == (src_code_i[g] == '0))
                else $error("source index zero mismatch");
            p_src_bank_r1: assert ((src_addr_o[g] == '0) ||
                                   ((src_addr_o[g] > BASE_IDX) &&
                                    (src_addr_o[g] < BASE_IDX + BASE_IDX)))
                else $error("source index outside compact bank");
        end
    end

    assign dst_addr_o = BASE_IDX + REG_AW'(dst_code_i);

    always_comb begin
        p_dst_bank_r2: assert ((dst_addr_o >= BASE_IDX) &&
                               (dst_addr_o < BASE_IDX + BASE_IDX))
            else $error("destination index outside compact bank");
    end

endmodule

// File: rtl/fia_decode.sv
module fia_decode
    import fia_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int SPEC_W = 3
) (
    input  logic [31:0]       instr_i,
    output fia_op_e           op_o,
    output logic [XLEN-1:0]   imm_o,
    output logic [SPEC_W-1:0] rs1_code_o,
    output logic [SPEC_W-1:0] rs2_code_o,
    output logic [SPEC_W-1:0] rs3_code_o,
    output logic [SPEC_W-1:0] rd_code_o
);

    localparam int IMM_S_W = 9;
    localparam int IMM_L_W = 12;

    fia_fields_t f;
    logic        hit_two;
    logic        hit_three;
    logic        hit_rsub;
    logic [2:0]  hits;

    assign f = split_word(instr_i);

    assign rs1_code_o = f.rs1_code;
    assign rs2_code_o = f.rs2_code;
    assign rs3_code_o = f.rs3_code;
    assign rd_code_o  = f.rd_code;

    assign hit_two   = (f.opcode == OPC_MISC_MEM) && (f.grp == GRP_TWO_SRC) &&
                       (f.sel3 == 3'b000);
    assign hit_three = (f.opcode == OPC_MISC_MEM) && (f.grp == GRP_THREE_SRC) &&
                       (f.sel3 == 3'b000) && (f.top2 == 2'b00) &&
                       (f.nibble == 4'b0000) && !f.sub[1];
    assign hit_rsub  = (f.opcode == OPC_OP_IMM_32) && (f.grp == GRP_REV_SUB) &&
                       (f.sel3 == 3'b000) && !f.sub[1];

    assign hits = {hit_two, hit_three, hit_rsub};

    always_comb begin
        op_o  = OP_NONE;
        imm_o = '0;
        unique case (1'b1)
            hit_two: begin
                imm_o = {{(XLEN-IMM_S_W){instr_i[31]}}, instr_i[31:31-IMM_S_W+1]};
                unique case (f.sub)
                    2'b00:   op_o = OP_MULADD;
                    2'b01:   op_o = OP_MULADDW;
                    2'b10:   op_o = OP_ADDADD;
                    default: op_o = OP_ADDADDW;
                endcase
            end
            hit_three: begin
                op_o = f.sub[0] ? OP_ADD3W : OP_ADD3;
            end
            hit_rsub: begin
                imm_o = {{(XLEN-IMM_L_W){instr_i[31]}}, instr_i[31:31-IMM_L_W+1]};
                op_o  = f.sub[0] ? OP_RSUBW : OP_RSUB;
            end
            default: begin
                op_o  = OP_NONE;
                imm_o = '0;
            end
        endcase
    end

    always_comb begin
        p_one_group_r8: assert ($onehot0(hits))
            else $error("more than one encoding group matched");
        p_none_no_hit_r8: assert ((op_o == OP_NONE) == (hits == 3'b000))
            else $error("operation selection disagrees with group match");
    end

endmodule

// File: rtl/fia_alu.sv
module fia_alu
    import fia_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  fia_op_e         op_i,
    input  logic [XLEN-1:0] src1_i,
    input  logic [XLEN-1:0] src2_i,
    input  logic [XLEN-1:0] src3_i,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] res_o
);

    localparam int EXT_W = XLEN - WLEN;

    logic [XLEN-1:0] prod;
    logic [XLEN-1:0] raw;
    logic            word_sel;

    assign prod     = src1_i * imm_i;
    assign word_sel = op_is_word(op_i);

    always_comb begin
        raw = '0;
        unique case (op_i)
            OP_MULADD, OP_MULADDW: raw = prod + src2_i;
            OP_ADDADD, OP_ADDADDW: raw = src1_i + imm_i + src2_i;
            OP_RSUB,   OP_RSUBW:   raw = imm_i - src1_i;
            OP_ADD3,   OP_ADD3W:   raw = src1_i + src2_i + src3_i;
            default:               raw = '0;
        endcase
    end

    always_comb begin
        if (word_sel) begin
            res_o = {{EXT_W{raw[WLEN-1]}}, raw[WLEN-1:0]};
        end else begin
            res_o = raw;
        end
    end

    always_comb begin
        if ((op_i == OP_RSUB) && (src1_i == '0)) begin
            p_rsub_zero_src_r5: assert (res_o == imm_i)
                else $error("reverse subtract of zero must return immediate");
        end
        if ((op_i == OP_ADDADD) && (imm_i == '0)) begin
            p_addadd_no_imm_r4: assert (res_o == src1_i + src2_i)
                else $error("add-add with zero immediate mismatch");
        end
        if (op_i == OP_NONE) begin
            p_none_zero_r8: assert (res_o == '0)
                else $error("unrecognised word gave nonzero result");
        end
    end

endmodule

// File: rtl/fia_unit.sv
module fia_unit
    import fia_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int WLEN   = 32,
    parameter int SPEC_W = 3,
    parameter int REG_AW = 5
) (
    input  logic [31:0]       instr_i,
    output logic [REG_AW-1:0] rs1_addr_o,
    output logic [REG_AW-1:0] rs2_addr_o,
    output logic [REG_AW-1:0] rs3_addr_o,
    output logic [REG_AW-1:0] rd_addr_o,
    input  logic [XLEN-1:0]   rs1_data_i,
    input  logic [XLEN-1:0]   rs2_data_i,
    input  logic [XLEN-1:0]   rs3_data_i,
    output logic [XLEN-1:0]   result_o,
    output logic              wr_en_o
);

    localparam int NSRC = 3;

    fia_op_e           op;
    logic [XLEN-1:0]   imm;
    logic [SPEC_W-1:0] src_code [NSRC];
    logic [REG_AW-1:0] src_addr [NSRC];
    logic [SPEC_W-1:0] dst_code;

    fia_decode #(
        .XLEN   (XLEN),
        .SPEC_W (SPEC_W)
    ) u_decode (
        .instr_i    (instr_i),
        .op_o       (op),
        .imm_o      (imm),
        .rs1_code_o (src_code[0]),
        .rs2_code_o (src_code[1]),
        .rs3_code_o (src_code[2]),
        .rd_code_o  (dst_code)
    );

    fia_regmap #(
        .NSRC   (NSRC),
        .SPEC_W (SPEC_W),
        .REG_AW (REG_AW)
    ) u_regmap (
        .src_code_i (src_code),
        .dst_code_i (dst_code),
        .src_addr_o (src_addr),
        .dst_addr_o (rd_addr_o)
    );

    assign rs1_addr_o = src_addr[0];
    assign rs2_addr_o = src_addr[1];
    assign rs3_addr_o = src_addr[2];

    fia_alu #(
        .XLEN (XLEN),
        .WLEN (WLEN)
    ) u_alu (
        .op_i   (op),
        .src1_i (rs1_data_i),
        .src2_i (rs2_data_i),
        .src3_i (rs3_data_i),
        .imm_i  (imm),
        .res_o  (result_o)
    );

    assign wr_en_o = (op != OP_NONE);

    always_comb begin
        if (!wr_en_o) begin
            p_no_write_zero_r8: assert (result_o == '0)
                else $error("result nonzero without write request");
        end
        if (wr_en_o && op_is_word(op)) begin
            p_word_sext_r7: assert (result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}})
                else $error("word result not sign-extended");
        end
        if ((op == OP_MULADD) && (rs2_addr_o == '0) && (rs2_data_i == '0)) begin
            p_mul_only_r3: assert (result_o == rs1_data_i * imm)
                else $error("zero second source must give plain product");
        end
    end

endmodule

// File: tb/sim_fia_unit.sv
module sim_fia_unit;

    logic        clk;
    logic        rst_n;
    logic [31:0] instr;
    logic [4:0]  rs1_addr, rs2_addr, rs3_addr, rd_addr;
    logic [63:0] rs1_data, rs2_data, rs3_data;
    logic [63:0] result;
    logic        wr_en;

    logic [63:0] rf [16];

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    fia_unit u0 (
        .instr_i    (instr),
        .rs1_addr_o (rs1_addr),
        .rs2_addr_o (rs2_addr),
        .rs3_addr_o (rs3_addr),
        .rd_addr_o  (rd_addr),
        .rs1_data_i (rs1_data),
        .rs2_data_i (rs2_data),
        .rs3_data_i (rs3_data),
        .result_o   (result),
        .wr_en_o    (wr_en)
    );

    assign rs1_data = (rs1_addr == 5'd0) ? 64'd0 : rf[rs1_addr[3:0]];
    assign rs2_data = (rs2_addr == 5'd0) ? 64'd0 : rf[rs2_addr[3:0]];
    assign rs3_data = (rs3_addr == 5'd0) ? 64'd0 : rf[rs3_addr[3:0]];

    function automatic logic [31:0] enc_two(input logic [1:0] sub, input logic [8:0] imm9,
                                            input logic [2:0] s2, input logic [2:0] s1,
                                            input logic [2:0] d);
        return {imm9, s2, sub, s1, 2'b10, 3'b000, d, 7'b0001111};
    endfunction

    function automatic logic [31:0] enc_three(input logic [1:0] sub, input logic [2:0] s3,
                                              input logic [2:0] s2, input logic [2:0] s1,
                                              input logic [2:0] d);
        return {2'b00, s3, 4'b0000, s2, sub, s1, 2'b11, 3'b000, d, 7'b0001111};
    endfunction

    function automatic logic [31:0] enc_rsub(input logic [1:0] sub, input logic [11:0] imm12,
                                             input logic [2:0] s1, input logic [2:0] d);
        return {imm12, sub, s1, 2'b11, 3'b000, d, 7'b0011011};
    endfunction

    function automatic logic [4:0] exp_src(input logic [2:0] c);
        return (c == 3'd0) ? 5'd0 : 5'(c) + 5'd8;
    endfunction

    function automatic logic [63:0] regval(input logic [2:0] c);
        return (c == 3'd0) ? 64'd0 : rf[4'(c) + 4'd8];
    endfunction

    function automatic logic [63:0] wsext(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    // Reference model from R3..R9
    function automatic void ref_model(input logic [31:0] w, output logic [63:0] res,
                                      output logic ok, output string tag);
        logic [63:0] a, b, c, i9, i12;
        a   = regval(w[17:15]);
        b   = regval(w[22:20]);
        c   = regval(w[29:27]);
        i9  = {{55{w[31]}}, w[31:23]};
        i12 = {{52{w[31]}}, w[31:20]};
        res = 64'd0;
        ok  = 1'b0;
        tag = "R8";
        if (w[6:0] == 7'b0001111 && w[14:13] == 2'b10 && w[12:10] == 3'b000) begin
            ok = 1'b1;
            case (w[19:18])
                2'b00: begin res = a * i9 + b;        tag = "R3"; end
                2'b01: begin res = wsext(a * i9 + b); tag = "R7"; end
                2'b10: begin res = a + i9 + b;        tag = "R4"; end
                default: begin res = wsext(a + i9 + b); tag = "R7"; end
            endcase
        end else if (w[6:0] == 7'b0001111 && w[14:13] == 2'b11 && w[12:10] == 3'b000 &&
                     w[31:30] == 2'b00 && w[26:23] == 4'd0 && w[19] == 1'b0) begin
            ok = 1'b1;
            if (w[18]) begin res = wsext(a + b + c); tag = "R7"; end
            else       begin res = a + b + c;        tag = "R6"; end
        end else if (w[6:0] == 7'b0011011 && w[14:13] == 2'b11 && w[12:10] == 3'b000 &&
                     w[19] == 1'b0) begin
            ok = 1'b1;
            if (w[18]) begin res = wsext(i12 - a); tag = "R7"; end
            else       begin res = i12 - a;        tag = "R5"; end
        end
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s instr=%h actual=%h expected=%h", req, instr, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input string extra);
        logic [63:0] er;
        logic        eok;
        string       t;
        @(posedge clk);
        instr = w;
        @(negedge clk);
        ref_model(w, er, eok, t);
        chk("R1 rs1 index", 64'(rs1_addr), 64'(exp_src(w[17:15])));
        chk("R1 rs2 index", 64'(rs2_addr), 64'(exp_src(w[22:20])));
        chk("R1 rs3 index", 64'(rs3_addr), 64'(exp_src(w[29:27])));
        chk("R2 rd index",  64'(rd_addr),  64'(5'(w[9:7]) + 5'd8));
        chk({"R8 write flag ", extra}, 64'(wr_en), 64'(eok));
        chk({t, " result ", extra}, result, er);
    endtask

    function automatic logic [63:0] rnd_val();
        case ($urandom_range(0, 5))
            0: return 64'd0;
            1: return 64'h0000_0000_7FFF_FFFF;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    task automatic fill_rf();
        for (int k = 0; k < 16; k++) rf[k] = rnd_val();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        instr = 32'd0;
        for (int k = 0; k < 16; k++) rf[k] = 64'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // reset state: all-zero word is not recognised (R8)
        chk("R8 reset write flag", 64'(wr_en), 64'd0);
        chk("R8 reset result", result, 64'd0);
        rst_n = 1'b1;

        fill_rf();
        rf[9]  = 64'd7;
        rf[10] = 64'd100;
        rf[11] = 64'h0000_0000_7FFF_FFFF;
        rf[12] = 64'd1;
        rf[13] = 64'h0000_0000_8000_0000;
        // R3: zero second source gives plain product
        apply(enc_two(2'b00, 9'd5, 3'd0, 3'd1, 3'd2), "R3 mul only");
        chk("R3 7*5", result, 64'd35);
        // R9: negative imm9 = -1
        apply(enc_two(2'b00, 9'h1FF, 3'd2, 3'd1, 3'd0), "R9 imm9 -1");
        chk("R9 -7+100", result, 64'd93);
        // R4 and R9: most negative imm9 (-256)
        apply(enc_two(2'b10, 9'h100, 3'd2, 3'd1, 3'd7), "R4 imm -256");
        chk("R4 7-256+100", result, 64'd7 - 64'd256 + 64'd100);
        // R7: word overflow across bit 31
        apply(enc_two(2'b11, 9'd0, 3'd4, 3'd3, 3'd1), "R7 addadd word");
        chk("R7 word wrap", result, 64'hFFFF_FFFF_8000_0000);
        // R5 and R9: imm12 = -2048
        apply(enc_rsub(2'b00, 12'h800, 3'd1, 3'd3), "R5 imm -2048");
        chk("R5 -2048-7", result, 64'hFFFF_FFFF_FFFF_F7F9);
        apply(enc_rsub(2'b01, 12'h7FF, 3'd5, 3'd3), "R7 rsub word");
        chk("R7 2047-0x80000000", result, 64'hFFFF_FFFF_8000_07FF);
        // R6: three-way add
        apply(enc_three(2'b00, 3'd3, 3'd2, 3'd1, 3'd6), "R6 add3");
        chk("R6 sum", result, 64'd107 + 64'h7FFF_FFFF);
        apply(enc_three(2'b01, 3'd4, 3'd3, 3'd0, 3'd6), "R7 add3 word");
        chk("R7 add3 word", result, 64'hFFFF_FFFF_8000_0000);
        // R8: near-miss encodings
        apply(enc_three(2'b00, 3'd3, 3'd2, 3'd1, 3'd6) | 32'h0080_0000, "R8 nibble nonzero");
        apply(enc_three(2'b00, 3'd3, 3'd2, 3'd1, 3'd6) | 32'h4000_0000, "R8 top bits nonzero");
        apply(enc_three(2'b10, 3'd3, 3'd2, 3'd1, 3'd6), "R8 add3 bad sub");
        apply(enc_rsub(2'b10, 12'd5, 3'd1, 3'd0), "R8 rsub bad sub");
        apply(enc_two(2'b00, 9'd3, 3'd1, 3'd1, 3'd1) | 32'h0000_0400, "R8 bad f3");
        apply(enc_two(2'b00, 9'd3, 3'd1, 3'd1, 3'd1) ^ 32'h0000_0001, "R8 bad opcode");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            fill_rf();
            case ($urandom_range(0, 4))
                0: w = enc_two(2'($urandom), 9'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
                1: w = enc_three(2'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
                2: w = enc_rsub(2'($urandom), 12'($urandom), 3'($urandom), 3'($urandom));
                3: begin
                    w = enc_three(2'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
                    w = w ^ (32'd1 << $urandom_range(0, 31));
                end
                default: w = $urandom;
            endcase
            apply(w, "random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule